// File: doc/BRIEF.md
# NAND Page-Program Command Interface

This block is the device side of a small-page NAND flash, limited to the program path. It takes write and read cycles on an 8-bit bus. Command-latch and address-latch qualifiers select the kind of each write cycle, and active-low write and read strobes mark the cycles. The bus is split into a `din` input and a `dout` output.

A load command opens a program sequence. Three address cycles follow: the column low byte, the column high bits and the page number. Data bytes then go into a 528-byte page register, starting at the chosen column. A confirm command starts a timed program of that page into an on-chip cell array. While the program runs, the ready/busy output is low and the block accepts only a small set of commands. The result can be read through a status byte.

Programming can only clear bits. Each page also has a budget of partial programs between erases. The budget is counted separately for the 512-byte main area and for the 16-byte spare area. A program that goes over either budget reports a failure and leaves the page unchanged. A read command with the same three address cycles streams array bytes back, so that programmed contents can be observed. Each strobe all the clocked logic sees is one clock cycle long, with `we_n` or `re_n` held low.

Top module: `nand_prog_if`

## Requirements
- R1: The load sequence is command 80h, then three address cycles: column[7:0], then column[9:8] in din[1:0], then the page number in the low bits of din. The data bytes that follow are stored at consecutive columns from the start column. Data bytes that arrive once the column has reached 528 are ignored.
- R2: Command 10h starts a program only when the most recent accepted command was 80h and all three of its address cycles have been given. Otherwise 10h is ignored: rb_n stays high and the command mode does not change.
- R3: Command 80h fills the whole page register with FFh. Page bytes that are not loaded therefore leave their cells unchanged.
- R4: While rb_n is low, only 70h and FFh are accepted. Every other command, every address cycle and every data cycle is ignored.
- R5: The status byte has bit 6 = 1 when ready and bit 0 = 1 when the last program failed. All other bits are 0. After a valid 10h, rb_n is low for exactly PROG_CYCLES clock cycles.
- R6: A program leaves each cell equal to the AND of its previous value and the loaded byte.
- R7: After 70h, every read cycle returns the status byte, until another command is accepted.
- R8: Each page counts its successful partial programs separately: at most 2 for the main area (columns 0 to 511) and at most 3 for the spare area (columns 512 to 527). A program that would go over either limit sets the fail bit and leaves the page unchanged. Pages are counted independently.
- R9: Command FFh is accepted at any time. It ends a running program at once, so rb_n is high from the next cycle, and it returns the mode to idle and clears the fail bit.
- R10: After 00h and three address cycles, each read cycle returns the array byte at the current column during the same cycle, and the column advances at the clock edge. Columns of 528 or more, and read cycles outside read or status mode, return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the array returns to the erased state (all FFh) |
| cle | input | 1 | Command-latch qualifier for a write cycle |
| ale | input | 1 | Address-latch qualifier for a write cycle |
| we_n | input | 1 | Active-low write strobe, sampled on each clock edge |
| re_n | input | 1 | Active-low read strobe; advances the read column on the clock edge |
| din | input | 8 | Bus byte written by the host |
| dout | output | 8 | Bus byte returned during a read cycle |
| rb_n | output | 1 | Ready/busy; low while a program runs |

## Verification
The main function is driven with loads that stop short of the page end, so that the untouched bytes show the FFh fill. A second, overlapping load with a different byte pattern separates a true AND from plain overwriting. A load that starts two bytes before the page end and runs past it shows where storage stops. A series of spare-only programs on one page, followed by a main-area program on the same page and on the other page, shows whether the limits are counted per area and per page. Commands issued during the busy window, and a lone confirm, show which commands are accepted in which state.

// File: rtl/nand_pkg.sv
package nand_pkg;
    localparam int MAIN_BYTES  = 512;
    localparam int SPARE_BYTES = 16;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam int COL_W       = 10;
    localparam int CNT_W       = 2;
    localparam int MAIN_LIMIT  = 2;
    localparam int SPARE_LIMIT = 3;

    localparam logic [7:0] OP_READ = 8'h00;
    localparam logic [7:0] OP_LOAD = 8'h80;
    localparam logic [7:0] OP_GO   = 8'h10;
    localparam logic [7:0] OP_STAT = 8'h70;
    localparam logic [7:0] OP_RST  = 8'hFF;

    typedef enum logic [1:0] {MD_NONE, MD_READ, MD_LOAD, MD_STAT} mode_e;

    typedef struct packed {
        logic cmd;
        logic adr;
        logic dat;
        logic rd;
    } cyc_t;

    function automatic cyc_t decode_cycle(input logic cle, input logic ale,
                                          input logic we_n, input logic re_n);
        cyc_t c;
        c.cmd = !we_n && cle && !ale;
        c.adr = !we_n && ale && !cle;
        c.dat = !we_n && !cle && !ale;
        c.rd  = !re_n && we_n;
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input logic ready, input logic fail);
        return {1'b0, ready, 5'b00000, fail};
    endfunction
endpackage

// File: rtl/nand_page_reg.sv
module nand_page_reg
    import nand_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             we,
    input  logic [COL_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [COL_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] buf_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
        end else if (we) begin
            buf_q[widx] <= wdata;
        end
    end

    assign rdata = buf_q[ridx];

    // R3: a load command leaves the page register erased at both ends
    assert_clear_fill_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> (buf_q[0] == 8'hFF && buf_q[PAGE_BYTES-1] == 8'hFF));
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array
    import nand_pkg::*;
#(
    parameter int PAGES = 2,
    localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PG_W-1:0]  wpage,
    input  logic [COL_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [PG_W-1:0]  rpage,
    input  logic [COL_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] cell_q [PAGES][PAGE_BYTES];
    logic [7:0] old_byte;

    assign old_byte = cell_q[wpage][widx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PAGES; p++)
                for (int i = 0; i < PAGE_BYTES; i++) cell_q[p][i] <= 8'hFF;
        end else if (we) begin
            cell_q[wpage][widx] <= old_byte & wdata;
        end
    end

    assign rdata = cell_q[rpage][ridx];

    // R6: a program write never sets a bit that was clear
    assert_only_clears_R6: assert property (@(posedge clk) disable iff (rst)
        we |=> ((cell_q[$past(wpage)][$past(widx)] | $past(old_byte)) == $past(old_byte)));
endmodule

// File: rtl/nand_cmd_ctl.sv
module nand_cmd_ctl
    import nand_pkg::*;
#(
    parameter int PAGES       = 2,
    parameter int PROG_CYCLES = 600,
    localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int T_W  = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_t             cyc,
    input  logic [7:0]       din,
    output mode_e            mode_o,
    output logic             busy_o,
    output logic             fail_o,
    output logic             rd_ok_o,
    output logic [COL_W-1:0] col_o,
    output logic [PG_W-1:0]  page_o,
    output logic             pr_clear_o,
    output logic             pr_wr_o,
    output logic             arr_wr_o,
    output logic [COL_W-1:0] arr_idx_o
);
    mode_e              mode;
    logic [1:0]         addr_cnt;
    logic [COL_W-1:0]   col;
    logic [PG_W-1:0]    page;
    logic               busy, fail, skip, t_main, t_spare;
    logic [T_W-1:0]     tcnt;
    logic [CNT_W-1:0]   main_cnt  [PAGES];
    logic [CNT_W-1:0]   spare_cnt [PAGES];
    logic               armed, over, go, in_page;

    assign in_page = col < COL_W'(PAGE_BYTES);
    assign armed   = (mode == MD_LOAD) && (addr_cnt == 2'd3);
    assign over    = (t_main  && main_cnt[page]  >= CNT_W'(MAIN_LIMIT)) ||
                     (t_spare && spare_cnt[page] >= CNT_W'(SPARE_LIMIT));
    assign go      = cyc.cmd && din == OP_GO && armed && !busy;

    assign pr_clear_o = cyc.cmd && ((din == OP_LOAD && !busy) || din == OP_RST);
    assign pr_wr_o    = cyc.dat && !busy && armed && in_page;
    assign arr_wr_o   = busy && !skip && tcnt < T_W'(PAGE_BYTES);
    assign arr_idx_o  = COL_W'(tcnt);
    assign rd_ok_o    = (mode == MD_READ) && (addr_cnt == 2'd3) && in_page;
    assign mode_o     = mode;
    assign busy_o     = busy;
    assign fail_o     = fail;
    assign col_o      = col;
    assign page_o     = page;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MD_NONE; addr_cnt <= '0; col <= '0; page <= '0;
            busy <= 1'b0; fail <= 1'b0; skip <= 1'b0; tcnt <= '0;
            t_main <= 1'b0; t_spare <= 1'b0;
            for (int p = 0; p < PAGES; p++) begin
                main_cnt[p]  <= '0;
                spare_cnt[p] <= '0;
            end
        end else if (busy) begin
            if (cyc.cmd && din == OP_RST) begin
                busy <= 1'b0; tcnt <= '0; mode <= MD_NONE; fail <= 1'b0;
            end else begin
                if (cyc.cmd && din == OP_STAT) mode <= MD_STAT;
                if (tcnt == T_W'(PROG_CYCLES - 1)) begin
                    busy <= 1'b0; tcnt <= '0;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end else begin
            if (cyc.cmd) begin
                case (din)
                    OP_LOAD: begin mode <= MD_LOAD; addr_cnt <= '0; t_main <= 1'b0; t_spare <= 1'b0; end
                    OP_READ: begin mode <= MD_READ; addr_cnt <= '0; end
                    OP_STAT: mode <= MD_STAT;
                    OP_RST:  begin mode <= MD_NONE; fail <= 1'b0; end
                    OP_GO: if (armed) begin
                        busy <= 1'b1; tcnt <= '0; mode <= MD_NONE;
                        fail <= over; skip <= over;
                        if (!over && t_main)  main_cnt[page]  <= main_cnt[page] + 1'b1;
                        if (!over && t_spare) spare_cnt[page] <= spare_cnt[page] + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (cyc.adr && (mode == MD_LOAD || mode == MD_READ) && addr_cnt != 2'd3) begin
                case (addr_cnt)
                    2'd0:    col[7:0] <= din;
                    2'd1:    col[COL_W-1:8] <= din[COL_W-9:0];
                    default: page <= din[PG_W-1:0];
                endcase
                addr_cnt <= addr_cnt + 1'b1;
            end
            if (pr_wr_o) begin
                col <= col + 1'b1;
                if (col < COL_W'(MAIN_BYTES)) t_main <= 1'b1;
                else t_spare <= 1'b1;
            end
            if (rd_ok_o && cyc.rd) col <= col + 1'b1;
        end
    end

    assert_lone_go_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc.cmd && din == OP_GO && !armed && !busy) |=> !busy);
    assert_busy_load_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && cyc.cmd && din == OP_LOAD) |=> (mode != MD_LOAD));
    assert_limit_sets_fail_R8: assert property (@(posedge clk) disable iff (rst)
        (go && over) |=> fail);
    assert_reset_cmd_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc.cmd && din == OP_RST) |=> (!busy && mode == MD_NONE && !fail));
endmodule

// File: rtl/nand_prog_if.sv
module nand_prog_if
    import nand_pkg::*;
#(
    parameter int PAGES       = 2,
    parameter int PROG_CYCLES = 600,
    localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       rb_n
);
    cyc_t             cyc;
    mode_e            mode;
    logic             busy, fail, rd_ok, pr_clear, pr_wr, arr_wr;
    logic [COL_W-1:0] col, arr_idx;
    logic [PG_W-1:0]  page;
    logic [7:0]       pr_rdata, arr_rdata;

    assign cyc = decode_cycle(cle, ale, we_n, re_n);

    nand_cmd_ctl #(.PAGES(PAGES), .PROG_CYCLES(PROG_CYCLES)) u_ctl (
        .clk(clk), .rst(rst), .cyc(cyc), .din(din),
        .mode_o(mode), .busy_o(busy), .fail_o(fail), .rd_ok_o(rd_ok),
        .col_o(col), .page_o(page), .pr_clear_o(pr_clear), .pr_wr_o(pr_wr),
        .arr_wr_o(arr_wr), .arr_idx_o(arr_idx)
    );

    nand_page_reg u_preg (
        .clk(clk), .rst(rst), .clear(pr_clear), .we(pr_wr),
        .widx(col), .wdata(din), .ridx(arr_idx), .rdata(pr_rdata)
    );

    nand_cell_array #(.PAGES(PAGES)) u_array (
        .clk(clk), .rst(rst), .we(arr_wr), .wpage(page), .widx(arr_idx),
        .wdata(pr_rdata), .rpage(page), .ridx(col), .rdata(arr_rdata)
    );

    always_comb begin
        dout = 8'h00;
        if (cyc.rd) begin
            if (mode == MD_STAT) dout = status_byte(!busy, fail);
            else if (rd_ok)      dout = arr_rdata;
        end
    end

    assign rb_n = !busy;
endmodule

// File: tb/tb_nand_prog_if.sv
module tb_nand_prog_if;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES      = 2;
    localparam int PROG_T     = 540;
    localparam int PB         = 528;

    logic clk = 1'b0, rst = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic rb_n;

    nand_prog_if #(.PAGES(PAGES), .PROG_CYCLES(PROG_T)) dut (
        .clk(clk), .rst(rst), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .din(din), .dout(dout), .rb_n(rb_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [PAGES][PB];
    int mcnt [PAGES];
    int scnt [PAGES];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic bus(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); cle = c; ale = a; din = b; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  bus(1'b1, 1'b0, b); endtask
    task automatic addr(input logic [7:0] b); bus(1'b0, 1'b1, b); endtask
    task automatic data(input logic [7:0] b); bus(1'b0, 1'b0, b); endtask

    task automatic rd_byte(output logic [7:0] v);
        @(negedge clk); re_n = 1'b0; #1 v = dout;
        @(negedge clk); re_n = 1'b1;
    endtask

    task automatic send_addr(input int pg, input int col);
        addr(8'(col)); addr(8'(col >> 8)); addr(8'(pg));
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rb_n) begin n++; @(negedge clk); end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 53 + (i >> 3)) ^ (seed << 2));
    endfunction

    // load n bytes from col on pg, confirm, update the model from R1/R3/R6/R8
    task automatic program_seq(input int pg, input int col, input int n, input int seed,
                               input bit probe, output int busy_n);
        bit tm = 0, ts = 0, f;
        logic [7:0] v;
        cmd(8'h80); send_addr(pg, col);
        for (int i = 0; i < n; i++) begin
            data(pat(seed, i));
            if (col + i < 512) tm = 1; else if (col + i < PB) ts = 1;
        end
        cmd(8'h10);
        if (probe) begin
            cmd(8'h70); rd_byte(v);
            check("R5 status while busy", v, 8'h00);
            cmd(8'h80); data(8'h55); cmd(8'h00); rd_byte(v);
            check("R4 commands ignored while busy keep status mode", v, 8'h00);
            check("R4 still busy", rb_n, 0);
        end
        wait_ready(busy_n);
        f = (tm && mcnt[pg] >= 2) || (ts && scnt[pg] >= 3);
        if (!f) begin
            if (tm) mcnt[pg]++;
            if (ts) scnt[pg]++;
            for (int i = 0; i < n; i++)
                if (col + i < PB) model[pg][col + i] = model[pg][col + i] & pat(seed, i);
        end
    endtask

    task automatic check_page(input int pg, input int col, input int n, input string req);
        logic [7:0] v;
        cmd(8'h00); send_addr(pg, col);
        for (int i = 0; i < n; i++) begin
            rd_byte(v);
            check(req, v, (col + i < PB) ? int'(model[pg][col + i]) : 0);
        end
    endtask

    task automatic read_status(output logic [7:0] v);
        cmd(8'h70); rd_byte(v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int bn;
        for (int p = 0; p < PAGES; p++) begin
            mcnt[p] = 0; scnt[p] = 0;
            for (int i = 0; i < PB; i++) model[p][i] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        check("R5 ready after reset", rb_n, 1);
        rd_byte(v);  check("R10 read with no mode returns 00h", v, 8'h00);
        read_status(v); check("R5 status after reset", v, 8'h40);

        cmd(8'h10);
        check("R2 lone confirm keeps ready", rb_n, 1);
        rd_byte(v);  check("R7 status mode persists after ignored 10h", v, 8'h40);

        program_seq(0, 0, 16, 1, 0, bn);
        check("R5 busy length", bn, PROG_T);
        read_status(v); check("R5 pass status", v, 8'h40);
        rd_byte(v);     check("R7 repeated status read", v, 8'h40);
        check_page(0, 0, 16, "R1 loaded bytes");
        check_page(0, 16, 8, "R3 unloaded bytes stay FFh");

        program_seq(0, 8, 16, 2, 0, bn);
        read_status(v); check("R6 second program status", v, 8'h40);
        check_page(0, 0, 32, "R6 AND of overlapping programs");

        program_seq(1, 526, 3, 9, 1, bn);
        rd_byte(v);     check("R7 status after busy ends", v, 8'h40);
        check_page(1, 524, 5, "R1 page end stops storage");

        program_seq(1, 512, 4, 3, 0, bn);
        read_status(v); check("R8 second spare program passes", v, 8'h40);
        program_seq(1, 520, 4, 4, 0, bn);
        read_status(v); check("R8 third spare program passes", v, 8'h40);
        program_seq(1, 514, 2, 5, 0, bn);
        read_status(v); check("R8 fourth spare program fails", v, 8'h41);
        check_page(1, 512, 16, "R8 failed program leaves spare unchanged");

        program_seq(0, 100, 4, 6, 0, bn);
        read_status(v); check("R8 third main program fails", v, 8'h41);
        check_page(0, 96, 12, "R8 failed program leaves main unchanged");

        cmd(8'hFF);
        read_status(v); check("R9 reset command clears fail", v, 8'h40);

        program_seq(1, 0, 8, 7, 0, bn);
        read_status(v); check("R8 limits counted per page", v, 8'h40);
        check_page(1, 0, 10, "R8 other page main programmed");

        cmd(8'h80); send_addr(1, 40); data(8'h00); data(8'h00); cmd(8'h10);
        check("R2 armed confirm starts busy", rb_n, 0);
        repeat (3) @(negedge clk);
        cmd(8'hFF);
        check("R9 abort returns ready", rb_n, 1);
        read_status(v); check("R9 status after abort", v, 8'h40);

        report();
        $finish;
    end
endmodule